// File: doc/BRIEF.md
# Banked System Address Decoder

This block sits between a CPU's 16-bit address bus and the memories and peripherals of an 8-bit system. For every address it raises exactly one region select line. It also produces the offset inside the selected memory. For the two memories that are larger than their CPU window, video RAM and work RAM, it adds the bank bits to that offset. Select and offset are combinational, so a memory can use them in the same cycle as the address.

The block holds two bank registers that the CPU writes at I/O addresses. One picks the video RAM bank, 0 or 1. The other picks which of work RAM banks 1 to 7 appears in the upper 4 KB work RAM window, and a value of 0 there still maps to bank 1. The region above work RAM mirrors work RAM. A small gap below the I/O page reads as FFh and drops writes. Reads of the two bank registers and of the gap are answered by the block itself, on a read data port with a hit flag.

Top module: `bank_sys_decoder`

## Requirements
- R1: `regionSel` bit k is set only for addresses in region k. The regions are: bit 0 0000–3FFF, bit 1 4000–7FFF, bit 2 8000–9FFF, bit 3 A000–BFFF, bit 4 C000–CFFF, bit 5 D000–DFFF, bit 6 E000–FDFF, bit 7 FE00–FE9F, bit 8 FEA0–FEFF, bit 9 FF00–FF7F, bit 10 FF80–FFFE, bit 11 FFFF.
- R2: For every address, exactly one bit of `regionSel` is set.
- R3: The offset for bits 0 and 1 is addr[13:0]. For bit 3 it is addr[13:0] with bit 13 cleared, which equals addr[12:0]. For bit 7 it is addr[7:0], and for bits 9 and 10 it is addr[6:0]. For bits 8 and 11 it is 0.
- R4: The offset for bit 2 is {video bank bit, addr[12:0]}.
- R5: The offset for bit 4 is addr[11:0], with the bank field [14:12] set to 0. For bit 5 it is {bank, addr[11:0]}, where bank is the work RAM register's low 3 bits, or 1 when those bits are 0.
- R6: An address in the mirror region (bit 6) gives the same offset as the address 2000h lower.
- R7: A write (`cpuWr`=1) to FF70 stores `cpuWrData[2:0]` in the work RAM register, and a write to FF4F stores `cpuWrData[0]` in the video bank bit. The stored value takes effect from the next rising clock edge.
- R8: A read (`cpuRd`=1) of FF70 returns {11111b, register}, and a read of FF4F returns {1111111b, bank bit}. In both cases `rdHit`=1.
- R9: A read of the gap (FEA0–FEFF) returns FFh with `rdHit`=1. A write to the gap changes no register.
- R10: After reset, both registers hold 0. A read of FF70 then returns F8h, and a read of FF4F returns FEh.
- R11: The registers do not change while `cpuWr` is 0. A read of any other address leaves `rdHit` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuAddr | input | 16 | CPU address |
| cpuRd | input | 1 | Read strobe |
| cpuWr | input | 1 | Write strobe |
| cpuWrData | input | 8 | Write data |
| regionSel | output | 12 | One-hot region select |
| physOffset | output | 15 | Offset inside the selected memory, bank bits included |
| rdData | output | 8 | Data for reads the block answers itself |
| rdHit | output | 1 | rdData is valid |

## Verification
The hardest case to reach from the ports is the mirror's upper half, F000–FDFF, with a non-trivial work RAM bank in the register. Its offset must match the banked window at D000–DDFF for whatever value was last written, including the value 0 that aliases bank 1. The stimulus gets there by steering random addresses toward FF70 and FF4F with random data, so the register values keep changing, and by interleaving accesses to the mirror and to the banked window. Directed steps then write 0, 7 and a value with stray upper bits, and compare D-page and F-page offsets after each write.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;
  localparam int ADDR_W      = 16;
  localparam int DATA_W      = 8;
  localparam int OFF_W       = 15;
  localparam int WBANK_W     = 3;
  localparam int PAGE_W      = 12;
  localparam int VWIN_W      = 13;
  localparam int NUM_REGIONS = 12;

  localparam int RG_ROM_FIX = 0;
  localparam int RG_ROM_SW  = 1;
  localparam int RG_VRAM    = 2;
  localparam int RG_CRAM    = 3;
  localparam int RG_WRAM0   = 4;
  localparam int RG_WRAMX   = 5;
  localparam int RG_MIRROR  = 6;
  localparam int RG_SPRITE  = 7;
  localparam int RG_GAP     = 8;
  localparam int RG_IO      = 9;
  localparam int RG_HRAM    = 10;
  localparam int RG_IE      = 11;

  localparam logic [ADDR_W-1:0] REGION_LO [NUM_REGIONS] = '{
    16'h0000, 16'h4000, 16'h8000, 16'hA000, 16'hC000, 16'hD000,
    16'hE000, 16'hFE00, 16'hFEA0, 16'hFF00, 16'hFF80, 16'hFFFF};
  localparam logic [ADDR_W-1:0] REGION_HI [NUM_REGIONS] = '{
    16'h3FFF, 16'h7FFF, 16'h9FFF, 16'hBFFF, 16'hCFFF, 16'hDFFF,
    16'hFDFF, 16'hFE9F, 16'hFEFF, 16'hFF7F, 16'hFFFE, 16'hFFFF};

  localparam logic [ADDR_W-1:0] WBANK_REG_ADDR = 16'hFF70;
  localparam logic [ADDR_W-1:0] VBANK_REG_ADDR = 16'hFF4F;

  typedef struct packed {
    logic [WBANK_W-1:0] wramRaw;
    logic [WBANK_W-1:0] wramBank;
    logic               vramBank;
    logic               wramRegRd;
    logic               vramRegRd;
  } bankCtl_t;
endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bankdec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [DATA_W-1:0] cpuWrData,
  output bankCtl_t          ctl
);
  logic [WBANK_W-1:0] wramQ;
  logic               vramQ;
  logic               hitW, hitV;

  assign hitW = (cpuAddr == WBANK_REG_ADDR);
  assign hitV = (cpuAddr == VBANK_REG_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wramQ <= '0;
      vramQ <= 1'b0;
    end else if (cpuWr) begin
      if (hitW) wramQ <= cpuWrData[WBANK_W-1:0];
      if (hitV) vramQ <= cpuWrData[0];
    end
  end

  always_comb begin
    ctl.wramRaw   = wramQ;
    ctl.wramBank  = (wramQ == '0) ? WBANK_W'(1) : wramQ;
    ctl.vramBank  = vramQ;
    ctl.wramRegRd = cpuRd && hitW;
    ctl.vramRegRd = cpuRd && hitV;
  end
endmodule

// File: rtl/bank_decode.sv
module bank_decode
  import bankdec_pkg::*;
(
  input  logic [ADDR_W-1:0]      cpuAddr,
  input  logic                   cpuRd,
  input  bankCtl_t               ctl,
  output logic [NUM_REGIONS-1:0] regionSel,
  output logic [OFF_W-1:0]       physOffset,
  output logic [DATA_W-1:0]      rdData,
  output logic                   rdHit
);
  for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_cmp
    assign regionSel[k] = (cpuAddr >= REGION_LO[k]) && (cpuAddr <= REGION_HI[k]);
  end

  logic [WBANK_W-1:0] pageBank;
  assign pageBank = cpuAddr[PAGE_W] ? ctl.wramBank : '0;

  always_comb begin
    physOffset = '0;
    unique case (1'b1)
      regionSel[RG_ROM_FIX],
      regionSel[RG_ROM_SW]:  physOffset = OFF_W'(cpuAddr[13:0]);
      regionSel[RG_VRAM]:    physOffset = OFF_W'({ctl.vramBank, cpuAddr[VWIN_W-1:0]});
      regionSel[RG_CRAM]:    physOffset = OFF_W'(cpuAddr[VWIN_W-1:0]);
      regionSel[RG_WRAM0],
      regionSel[RG_WRAMX],
      regionSel[RG_MIRROR]:  physOffset = OFF_W'({pageBank, cpuAddr[PAGE_W-1:0]});
      regionSel[RG_SPRITE]:  physOffset = OFF_W'(cpuAddr[7:0]);
      regionSel[RG_IO],
      regionSel[RG_HRAM]:    physOffset = OFF_W'(cpuAddr[6:0]);
      default:               physOffset = '0;
    endcase
  end

  always_comb begin
    rdHit  = 1'b0;
    rdData = '0;
    if (ctl.wramRegRd) begin
      rdHit  = 1'b1;
      rdData = {{(DATA_W-WBANK_W){1'b1}}, ctl.wramRaw};
    end else if (ctl.vramRegRd) begin
      rdHit  = 1'b1;
      rdData = {{(DATA_W-1){1'b1}}, ctl.vramBank};
    end else if (cpuRd && regionSel[RG_GAP]) begin
      rdHit  = 1'b1;
      rdData = '1;
    end
  end
endmodule

// File: rtl/bank_sys_decoder.sv
module bank_sys_decoder
  import bankdec_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      cpuAddr,
  input  logic                   cpuRd,
  input  logic                   cpuWr,
  input  logic [DATA_W-1:0]      cpuWrData,
  output logic [NUM_REGIONS-1:0] regionSel,
  output logic [OFF_W-1:0]       physOffset,
  output logic [DATA_W-1:0]      rdData,
  output logic                   rdHit
);
  bankCtl_t ctl;

  bank_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd),
    .cpuWr(cpuWr), .cpuWrData(cpuWrData), .ctl(ctl)
  );

  bank_decode i_dec (
    .cpuAddr(cpuAddr), .cpuRd(cpuRd), .ctl(ctl), .regionSel(regionSel),
    .physOffset(physOffset), .rdData(rdData), .rdHit(rdHit)
  );
endmodule

// File: rtl/bankdec_chk.sv
module bankdec_chk
  import bankdec_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      cpuAddr,
  input logic                   cpuRd,
  input logic                   cpuWr,
  input logic [DATA_W-1:0]      cpuWrData,
  input logic [NUM_REGIONS-1:0] regionSel,
  input logic [OFF_W-1:0]       physOffset,
  input logic [DATA_W-1:0]      rdData,
  input logic                   rdHit,
  input bankCtl_t               ctl
);
  // R2
  one_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(regionSel) == 1);

  // R7
  wbank_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr == WBANK_REG_ADDR) |=> ctl.wramRaw == $past(cpuWrData[WBANK_W-1:0]));

  // R11
  wbank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuWr |=> $stable(ctl.wramRaw) && $stable(ctl.vramBank));

  // R9
  gap_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && regionSel[RG_GAP]) |-> rdHit && rdData == '1);

  // R5
  wramx_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    regionSel[RG_WRAMX] |-> physOffset[OFF_W-1:PAGE_W] != '0);

  // R6
  mirror_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    regionSel[RG_MIRROR] |-> physOffset[PAGE_W-1:0] == cpuAddr[PAGE_W-1:0]);

  // R10
  reset_bank_chk: assert property (@(posedge clk)
    !rstN |=> ctl.wramRaw == '0 && !ctl.vramBank);
endmodule

bind bank_sys_decoder bankdec_chk i_chk (
  .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
  .cpuWrData(cpuWrData), .regionSel(regionSel), .physOffset(physOffset),
  .rdData(rdData), .rdHit(rdHit), .ctl(ctl)
);

// File: tb/test_bank_sys_decoder.sv
module test_bank_sys_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuRd = 1'b0, cpuWr = 1'b0;
  logic [7:0]  cpuWrData = '0;
  logic [11:0] regionSel;
  logic [14:0] physOffset;
  logic [7:0]  rdData;
  logic        rdHit;

  int nRun = 0, nFail = 0;
  logic [2:0] mW = '0;
  logic       mV = 1'b0;

  always #4 clk = ~clk;

  bank_sys_decoder i_bank_sys_decoder (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .cpuWrData(cpuWrData), .regionSel(regionSel), .physOffset(physOffset),
    .rdData(rdData), .rdHit(rdHit)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expIdx(logic [15:0] a);
    if (a <= 16'h3FFF) return 0;
    if (a <= 16'h7FFF) return 1;
    if (a <= 16'h9FFF) return 2;
    if (a <= 16'hBFFF) return 3;
    if (a <= 16'hCFFF) return 4;
    if (a <= 16'hDFFF) return 5;
    if (a <= 16'hFDFF) return 6;
    if (a <= 16'hFE9F) return 7;
    if (a <= 16'hFEFF) return 8;
    if (a <= 16'hFF7F) return 9;
    if (a <= 16'hFFFE) return 10;
    return 11;
  endfunction

  function automatic logic [14:0] expOff(logic [15:0] a);
    logic [2:0] eb = (mW == 3'd0) ? 3'd1 : mW;
    case (expIdx(a))
      0, 1:  return {1'b0, a[13:0]};
      2:     return {1'b0, mV, a[12:0]};
      3:     return {2'b0, a[12:0]};
      4:     return {3'b0, a[11:0]};
      5:     return {eb, a[11:0]};
      6:     return expOff(a - 16'h2000);
      7:     return {7'b0, a[7:0]};
      9, 10: return {8'b0, a[6:0]};
      default: return '0;
    endcase
  endfunction

  function automatic string offReq(logic [15:0] a);
    case (expIdx(a))
      2: return "R4";
      4, 5: return "R5";
      6: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic access(logic [15:0] a, logic rd, logic wr, logic [7:0] d);
    int k;
    @(negedge clk);
    cpuAddr = a; cpuRd = rd; cpuWr = wr; cpuWrData = d;
    #2;
    k = expIdx(a);
    check("R1", regionSel, 12'(1) << k);
    check("R2", $countones(regionSel), 1);
    check(offReq(a), physOffset, expOff(a));
    if (rd && a == 16'hFF70) begin
      check("R8", rdHit, 1); check("R8", rdData, {5'b11111, mW});
    end else if (rd && a == 16'hFF4F) begin
      check("R8", rdHit, 1); check("R8", rdData, {7'h7F, mV});
    end else if (rd && k == 8) begin
      check("R9", rdHit, 1); check("R9", rdData, 8'hFF);
    end else begin
      check("R11", rdHit, 0);
    end
    if (wr && a == 16'hFF70) mW = d[2:0];
    if (wr && a == 16'hFF4F) mV = d[0];
    @(posedge clk);
  endtask

  initial begin : watchdog
    #1_000_000;
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [15:0] bounds [25] = '{
      16'h0000, 16'h3FFF, 16'h4000, 16'h7FFF, 16'h8000, 16'h9FFF, 16'hA000,
      16'hBFFF, 16'hC000, 16'hCFFF, 16'hD000, 16'hDFFF, 16'hE000, 16'hEFFF,
      16'hF000, 16'hFDFF, 16'hFE00, 16'hFE9F, 16'hFEA0, 16'hFEFF, 16'hFF00,
      16'hFF7F, 16'hFF80, 16'hFFFE, 16'hFFFF};
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R10: reset values seen through register reads
    access(16'hFF70, 1, 0, 0); check("R10", rdData, 8'hF8);
    access(16'hFF4F, 1, 0, 0); check("R10", rdData, 8'hFE);
    foreach (bounds[i]) access(bounds[i], 1, 0, 0);
    // R7: writes take effect, value 0 aliases bank 1
    access(16'hFF70, 0, 1, 8'h00);
    access(16'hD123, 1, 0, 0); check("R7", physOffset, 15'h1123);
    access(16'hF123, 1, 0, 0); check("R6", physOffset, 15'h1123);
    access(16'hFF70, 0, 1, 8'hFD);
    access(16'hFF70, 1, 0, 0); check("R7", rdData, 8'hFD);
    access(16'hFDFF, 1, 0, 0); check("R6", physOffset, 15'h5DFF);
    access(16'hFF70, 0, 1, 8'h07);
    access(16'hDABC, 1, 0, 0); check("R5", physOffset, 15'h7ABC);
    access(16'hFF4F, 0, 1, 8'hFF);
    access(16'h9001, 1, 0, 0); check("R4", physOffset, 15'h3001);
    // R11: strobe low leaves registers alone
    access(16'hFF70, 1, 0, 8'h02);
    access(16'hFF70, 1, 0, 0); check("R11", rdData, 8'hFF);
    // R9: gap writes change nothing
    access(16'hFEA0, 0, 1, 8'h00);
    access(16'hFEFF, 0, 1, 8'h00);
    access(16'hFF70, 1, 0, 0); check("R9", rdData, 8'hFF);
    access(16'hFF4F, 1, 0, 0); check("R9", rdData, 8'hFF);
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      int pick = $urandom_range(0, 9);
      case (pick)
        0: a = 16'hFF70;
        1: a = 16'hFF4F;
        2: a = 16'hD000 | 16'($urandom_range(0, 16'h0FFF));
        3: a = 16'hF000 | 16'($urandom_range(0, 16'h0DFF));
        4: a = 16'hFE00 | 16'($urandom_range(0, 16'h01FF));
        default: a = 16'($urandom);
      endcase
      access(a, 1'($urandom), 1'($urandom), 8'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule